// File: doc/BRIEF.md
# Chip-Select Watchdog and Reset Supervisor

This block produces a system reset from three digital sources. The first is a supply-good level from an external comparator. The second is an external reset request. The third is a watchdog that expires when a serial chip-select line shows no activity for too long. The reset is driven on two registered outputs: `rst_hi`, which is active high, and `rst_lo_n`, its active-low complement.

All long intervals are counted in pulses of a slow `tick` input, for example one pulse per millisecond. The count limits are parameters, so a simulation can use short values. Once every source has been quiet for the full power-up timeout, the reset is released.

The supply-good input is filtered against short glitches. The chip-select line is synchronised to the core clock, and any edge on it restarts the watchdog. A 2-bit select chooses one of three watchdog periods or turns the watchdog off.

Top module: `cs_wdt_supervisor`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `rst_hi` = 1 and `rst_lo_n` = 0.
- R2: `rst_lo_n` is always the exact complement of `rst_hi`, and both come from flops.
- R3: `supply_ok` passes through a two-flop synchroniser. A new level is accepted only after it has held for `GLITCH_CYCLES` consecutive core clocks. Shorter pulses have no effect on the reset outputs.
- R4: Once a low `supply_ok` is accepted, `rst_hi` is 1 from the next cycle and stays 1 for as long as the accepted level stays low.
- R5: When no source is active, reset is released after `PUR_TICKS` ticks have been counted while it was held. If any source becomes active before then, the count restarts from zero.
- R6: `ext_req` is active high and level sensitive, and is synchronised with two flops. While it is seen high, reset is held, and when it drops a full R5 timeout follows.
- R7: `wd_sel` encodes the watchdog period: 2'b00 = `WD_LONG_TICKS`, 2'b01 = `WD_MID_TICKS`, 2'b10 = `WD_SHORT_TICKS`, 2'b11 = disabled. The watchdog expires on the tick that completes the period with no chip-select edge. Expiry gives a one-cycle pulse that asserts reset, followed by a full timeout. With 2'b11 selected, the watchdog never expires.
- R8: Any edge of `cs_n`, rising or falling, is seen after a two-flop synchroniser. Each such edge clears the watchdog count.
- R9: While `rst_hi` is 1, the watchdog does not count and stays cleared, so after release a full period must elapse before it can expire.
- R10: If `wd_sel` is changed to a period shorter than the count already reached, the watchdog expires on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle slow time-base pulse |
| supply_ok | input | 1 | Supply-good level from comparator, asynchronous |
| ext_req | input | 1 | External reset request, active high, asynchronous |
| cs_n | input | 1 | Serial chip-select line watched for activity, asynchronous |
| wd_sel | input | 2 | Watchdog period select (R7 encoding) |
| rst_hi | output | 1 | Reset, active high |
| rst_lo_n | output | 1 | Reset, active low |

## Verification
The bench builds the block with `GLITCH_CYCLES`=4, `PUR_TICKS`=5, and watchdog periods of 12, 8 and 4 ticks, with one tick every four clocks. These values make every interval a few dozen cycles long. As a result, glitches just under the filter width, a reset request repeated partway through a timeout, and repeated watchdog expiries all fit in a short run.

The small periods also make R10 reachable: a count built up under the long period is already past the short limit when the select switches.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/supv_glitch_filter.sv
module supv_glitch_filter #(
  parameter int GLITCH_CYCLES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = (GLITCH_CYCLES > 1) ? $clog2(GLITCH_CYCLES + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CYCLES - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b0;
      run  <= '0;
    end else if (din == dout) begin
      run <= '0;
    end else if (run >= LAST) begin
      dout <= din;
      run  <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/supv_wd_timer.sv
module supv_wd_timer
  import supv_pkg::*;
#(
  parameter int LONG_TICKS  = 1400,
  parameter int MID_TICKS   = 600,
  parameter int SHORT_TICKS = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       kick,
  input  logic       hold,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int MAXT = max3(LONG_TICKS, MID_TICKS, SHORT_TICKS);
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;
  wd_sel_e       mode;
  logic          off;

  assign mode = wd_sel_e'(sel);
  assign off  = (mode == WD_OFF);

  always_comb begin
    case (mode)
      WD_LONG:  lim_m1 = CW'(LONG_TICKS - 1);
      WD_MID:   lim_m1 = CW'(MID_TICKS - 1);
      WD_SHORT: lim_m1 = CW'(SHORT_TICKS - 1);
      default:  lim_m1 = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || hold || kick || off) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else if (tick) begin
      if (cnt >= lim_m1) begin
        cnt    <= '0;
        expire <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        expire <= 1'b0;
      end
    end else begin
      expire <= 1'b0;
    end
  end
endmodule

// File: rtl/supv_rst_timer.sv
module supv_rst_timer #(
  parameter int PUR_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic src_active,
  output logic rst_hi,
  output logic rst_lo_n
);
  localparam int CW = (PUR_TICKS > 1) ? $clog2(PUR_TICKS + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(PUR_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || src_active) begin
      cnt      <= '0;
      rst_hi   <= 1'b1;
      rst_lo_n <= 1'b0;
    end else if (rst_hi && tick) begin
      if (cnt >= LAST) begin
        cnt      <= '0;
        rst_hi   <= 1'b0;
        rst_lo_n <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cs_wdt_supervisor.sv
module cs_wdt_supervisor #(
  parameter int GLITCH_CYCLES  = 5,
  parameter int PUR_TICKS      = 200,
  parameter int WD_LONG_TICKS  = 1400,
  parameter int WD_MID_TICKS   = 600,
  parameter int WD_SHORT_TICKS = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       supply_ok,
  input  logic       ext_req,
  input  logic       cs_n,
  input  logic [1:0] wd_sel,
  output logic       rst_hi,
  output logic       rst_lo_n
);
  localparam int NSYNC = 3;
  localparam int IDX_SUP = 0;
  localparam int IDX_EXT = 1;
  localparam int IDX_CS  = 2;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] synced;
  logic             sup_ok_f;
  logic             ext_req_s;
  logic             cs_prev;
  logic             cs_edge;
  logic             wd_expire;
  logic             src_active;

  assign raw_in = {cs_n, ext_req, supply_ok};

  supv_sync2 #(.WIDTH(NSYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (synced)
  );

  supv_glitch_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_sup_filt (
    .clk  (clk),
    .rst  (rst),
    .din  (synced[IDX_SUP]),
    .dout (sup_ok_f)
  );

  assign ext_req_s = synced[IDX_EXT];

  always_ff @(posedge clk) begin
    if (rst) cs_prev <= 1'b0;
    else     cs_prev <= synced[IDX_CS];
  end

  assign cs_edge = synced[IDX_CS] ^ cs_prev;

  supv_wd_timer #(
    .LONG_TICKS  (WD_LONG_TICKS),
    .MID_TICKS   (WD_MID_TICKS),
    .SHORT_TICKS (WD_SHORT_TICKS)
  ) u_wd (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .kick   (cs_edge),
    .hold   (rst_hi),
    .sel    (wd_sel),
    .expire (wd_expire)
  );

  assign src_active = !sup_ok_f || ext_req_s || wd_expire;

  supv_rst_timer #(.PUR_TICKS(PUR_TICKS)) u_rst (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .src_active (src_active),
    .rst_hi     (rst_hi),
    .rst_lo_n   (rst_lo_n)
  );
endmodule

// File: rtl/cs_wdt_supervisor_chk.sv
module cs_wdt_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [1:0] wd_sel,
  input logic       rst_hi,
  input logic       rst_lo_n,
  input logic       sup_ok_f,
  input logic       ext_req_s,
  input logic       cs_edge,
  input logic       wd_expire
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d) begin
      assert_reset_state_R1: assert (rst_hi && !rst_lo_n)
        else $error("R1 reset state wrong");
    end
  end

  assert_complement_R2: assert property (@(posedge clk) disable iff (rst)
    rst_lo_n == !rst_hi);

  assert_supply_low_R4: assert property (@(posedge clk) disable iff (rst)
    !sup_ok_f |=> rst_hi);

  assert_release_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_hi) |-> $past(tick));

  assert_ext_holds_R6: assert property (@(posedge clk) disable iff (rst)
    ext_req_s |=> rst_hi);

  assert_expire_resets_R7: assert property (@(posedge clk) disable iff (rst)
    wd_expire |=> rst_hi);

  assert_off_never_expires_R7: assert property (@(posedge clk) disable iff (rst)
    wd_expire |-> ($past(wd_sel) != 2'b11));

  assert_kick_clears_R8: assert property (@(posedge clk) disable iff (rst)
    cs_edge |=> !wd_expire);

  assert_hold_in_reset_R9: assert property (@(posedge clk) disable iff (rst)
    wd_expire |-> $past(!rst_hi));
endmodule

bind cs_wdt_supervisor cs_wdt_supervisor_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .wd_sel    (wd_sel),
  .rst_hi    (rst_hi),
  .rst_lo_n  (rst_lo_n),
  .sup_ok_f  (sup_ok_f),
  .ext_req_s (ext_req_s),
  .cs_edge   (cs_edge),
  .wd_expire (wd_expire)
);

// File: tb/cs_wdt_supervisor_bench.sv
`timescale 1ns/1ps
module cs_wdt_supervisor_bench;
  localparam int G     = 4;
  localparam int PUR   = 5;
  localparam int WLONG = 12;
  localparam int WMID  = 8;
  localparam int WSHRT = 4;
  localparam int TDIV  = 4;
  localparam int LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       supply_ok = 1'b0;
  logic       ext_req = 1'b0;
  logic       cs_n = 1'b0;
  logic [1:0] wd_sel = 2'b11;
  logic       rst_hi;
  logic       rst_lo_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int tdiv = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  cs_wdt_supervisor #(
    .GLITCH_CYCLES (G),
    .PUR_TICKS     (PUR),
    .WD_LONG_TICKS (WLONG),
    .WD_MID_TICKS  (WMID),
    .WD_SHORT_TICKS(WSHRT)
  ) u_cs_wdt_supervisor (
    .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok),
    .ext_req(ext_req), .cs_n(cs_n), .wd_sel(wd_sel),
    .rst_hi(rst_hi), .rst_lo_n(rst_lo_n)
  );

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TDIV;
    tick = (tdiv == 0);
  end

  // Behavioural reference: integers and flags
  int m_sup[2], m_ext[2], m_cs[2];
  int m_csold, m_filt, m_run, m_wcnt, m_wexp, m_rcnt, m_rhi;

  always @(posedge clk) begin
    int srcact, kicked, lim, n_rhi, n_rcnt, n_wcnt, n_wexp, n_filt, n_run;
    if (rst) begin
      m_sup = '{0, 0}; m_ext = '{0, 0}; m_cs = '{0, 0};
      m_csold = 0; m_filt = 0; m_run = 0; m_wcnt = 0; m_wexp = 0;
      m_rcnt = 0; m_rhi = 1;
    end else begin
      srcact = (m_filt == 0) || (m_ext[1] != 0) || (m_wexp != 0);
      kicked = (m_cs[1] != m_csold);
      lim = (wd_sel == 2'b00) ? WLONG : (wd_sel == 2'b01) ? WMID : WSHRT;
      n_rhi = m_rhi; n_rcnt = m_rcnt;
      if (srcact) begin n_rhi = 1; n_rcnt = 0; end
      else if (m_rhi && tick) begin
        if (m_rcnt + 1 >= PUR) begin n_rhi = 0; n_rcnt = 0; end
        else n_rcnt = m_rcnt + 1;
      end
      n_wcnt = m_wcnt; n_wexp = 0;
      if (m_rhi || kicked || wd_sel == 2'b11) n_wcnt = 0;
      else if (tick) begin
        if (m_wcnt + 1 >= lim) begin n_wexp = 1; n_wcnt = 0; end
        else n_wcnt = m_wcnt + 1;
      end
      n_filt = m_filt; n_run = m_run;
      if (m_sup[1] == m_filt) n_run = 0;
      else if (m_run + 1 >= G) begin n_filt = m_sup[1]; n_run = 0; end
      else n_run = m_run + 1;
      m_csold = m_cs[1];
      m_sup[1] = m_sup[0]; m_sup[0] = int'(supply_ok);
      m_ext[1] = m_ext[0]; m_ext[0] = int'(ext_req);
      m_cs[1]  = m_cs[0];  m_cs[0]  = int'(cs_n);
      m_rhi = n_rhi; m_rcnt = n_rcnt; m_wcnt = n_wcnt; m_wexp = n_wexp;
      m_filt = n_filt; m_run = n_run;
    end
  end

  always @(negedge clk) begin
    if (running && !done) begin
      n_chk++;
      if (rst_hi !== m_rhi[0]) begin
        n_fail++;
        $display("FAIL %s cycle %0d: rst_hi=%0b expected %0b", cur_req, cyc, rst_hi, m_rhi[0]);
      end
      n_chk++;
      if (rst_lo_n !== ~rst_hi) begin
        n_fail++;
        $display("FAIL R2 cycle %0d: rst_lo_n=%0b expected %0b", cyc, rst_lo_n, ~rst_hi);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rst_hi=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      finish_run();
    end
  end

  initial begin
    waitn(5);
    chk("R1", rst_hi, 1'b1);
    chk("R1", rst_lo_n, 1'b0);
    running = 1'b1;
    rst = 1'b0;

    cur_req = "R4";
    waitn(30);
    chk("R4", rst_hi, 1'b1);

    cur_req = "R5";
    supply_ok = 1'b1;
    waitn(5);
    chk("R5", rst_hi, 1'b1);
    waitn(60);
    chk("R5", rst_hi, 1'b0);

    cur_req = "R3";
    supply_ok = 1'b0;
    waitn(G - 1);
    supply_ok = 1'b1;
    waitn(20);
    chk("R3", rst_hi, 1'b0);

    cur_req = "R4";
    supply_ok = 1'b0;
    waitn(10);
    chk("R4", rst_hi, 1'b1);
    waitn(30);
    chk("R4", rst_hi, 1'b1);
    supply_ok = 1'b1;
    waitn(60);
    chk("R4", rst_hi, 1'b0);

    cur_req = "R6";
    ext_req = 1'b1;
    waitn(2);
    ext_req = 1'b0;
    waitn(8);
    chk("R6", rst_hi, 1'b1);
    waitn(60);
    chk("R6", rst_hi, 1'b0);

    cur_req = "R5";
    ext_req = 1'b1; waitn(1); ext_req = 1'b0;
    waitn(16);
    ext_req = 1'b1; waitn(1); ext_req = 1'b0;
    waitn(16);
    chk("R5", rst_hi, 1'b1);
    waitn(60);
    chk("R5", rst_hi, 1'b0);

    cur_req = "R7";
    wd_sel = 2'b10;
    waitn(10);
    chk("R7", rst_hi, 1'b0);
    waitn(12);
    chk("R7", rst_hi, 1'b1);
    wd_sel = 2'b11;
    waitn(60);
    chk("R7", rst_hi, 1'b0);
    waitn(100);
    chk("R7", rst_hi, 1'b0);

    cur_req = "R8";
    wd_sel = 2'b10;
    for (int i = 0; i < 20; i++) begin
      cs_n = ~cs_n;
      waitn(6);
      if (i % 5 == 4) chk("R8", rst_hi, 1'b0);
    end

    cur_req = "R7";
    wd_sel = 2'b00;
    waitn(30);
    chk("R7", rst_hi, 1'b0);
    waitn(30);
    chk("R7", rst_hi, 1'b1);
    wd_sel = 2'b11;
    waitn(60);
    chk("R7", rst_hi, 1'b0);

    cur_req = "R10";
    wd_sel = 2'b00;
    waitn(36);
    chk("R10", rst_hi, 1'b0);
    wd_sel = 2'b10;
    waitn(8);
    chk("R10", rst_hi, 1'b1);
    wd_sel = 2'b11;
    waitn(60);
    chk("R10", rst_hi, 1'b0);

    cur_req = "R9";
    wd_sel = 2'b10;
    ext_req = 1'b1;
    waitn(60);
    chk("R9", rst_hi, 1'b1);
    ext_req = 1'b0;
    waitn(10);
    chk("R9", rst_hi, 1'b1);
    for (int i = 0; i < 100 && rst_hi; i++) @(negedge clk);
    waitn(8);
    chk("R9", rst_hi, 1'b0);
    wd_sel = 2'b11;
    waitn(10);

    finish_run();
  end
endmodule